// File: doc/BRIEF.md
# Four-Channel Threshold Trigger Serializer

This block turns four parallel sample channels into one serial trigger line. Each channel has its own programmable threshold, held in a register that software writes and reads over a small register bus. When the sample stream offers a new set of four samples, the block compares every sample with its channel's threshold. It captures all four verdicts at once and plays them out on the trigger line in channel order. Each verdict holds the line for one fixed slot. With the default of one slot per clock period, a 20 MHz clock gives 50 ns slots. Channels 2, 3 and 4 then trail channel 1 by 50, 100 and 150 ns.

The sample input is a valid/ready stream. A set of samples is taken on a clock edge where `smp_valid` and `smp_ready` are both high. The block can hold one set of verdicts while a frame is on the line, so `smp_ready` drops only while that one set is waiting. While `smp_ready` is low the producer must keep its data and must not expect it to be consumed. The waiting set goes out directly after the current frame, with no gap. Thresholds reset to all ones, so the line stays quiet until software programs them. Estimating pedestal and noise levels is left to software.

Top module: `trig_serializer`

## Requirements
- R1: After reset `trig_line` is 0, `smp_ready` is 1 and every threshold reads back as all ones (0x3FF), so even full-scale samples produce all-zero frames.
- R2: A write with `cfg_addr` 0, 1, 2 or 3 sets the threshold of channel 1, 2, 3 or 4, and that channel's value reads back on `cfg_rdata` while that address is applied.
- R3: Reads of any address of 4 or above return 0, and writes to such addresses leave all four thresholds unchanged.
- R4: A channel's verdict is 1 only when its sample is strictly greater than its threshold; a sample equal to the threshold gives 0.
- R5: Channel k's sample sits in `smp_data[10k-1:10(k-1)]`. In the clock after an accepting edge, the line carries channel 1's verdict. Channels 2, 3 and 4 follow in that order, each for `SLOT_CYCLES` clocks.
- R6: Outside a frame `trig_line` is 0.
- R7: Verdicts are latched at the accepting edge. Sample data and threshold writes that arrive during a frame do not alter that frame.
- R8: A set accepted during a frame is held, drives `smp_ready` low, and its frame starts in the clock right after the current frame ends.
- R9: While `smp_ready` is low a high `smp_valid` is not consumed, so no extra frame results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (20 MHz in service) |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample set offered |
| smp_ready | output | 1 | Block can take a sample set |
| smp_data | input | 40 | Four 10-bit samples, channel 1 in the low bits |
| cfg_wr_en | input | 1 | Threshold register write strobe |
| cfg_addr | input | 3 | Threshold register address |
| cfg_wdata | input | 10 | Threshold write value |
| cfg_rdata | output | 10 | Threshold read value for `cfg_addr` |
| trig_line | output | 1 | Serial trigger line |

## Verification
The bench runs with two clocks per slot. A design that miscounted slot length, or started the frame one clock late, then shows the wrong channel at a sampled clock. Samples exactly at threshold catch a compare that uses greater-or-equal. Mixed patterns catch a reversed channel order. In one test, samples and a threshold are changed mid-frame. A design that compared live inputs instead of latched verdicts would then send altered bits. In the back-to-back test, a second set arrives mid-frame and valid stays high with a third set. A design that dropped the held set would leave a gap. A design that ignored back-pressure would play out a third frame.

// File: rtl/trig_serializer_pkg.sv
package trig_serializer_pkg;
  typedef enum logic {
    SER_IDLE = 1'b0,
    SER_SEND = 1'b1
  } ser_state_e;
endpackage

// File: rtl/trig_thr_regs.sv
module trig_thr_regs #(
  parameter int NCH    = 4,
  parameter int DW     = 10,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [NCH*DW-1:0] thr_flat
);
  logic [DW-1:0] thr_q [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) thr_q[i] <= '1;
      else if (wr_en && addr == ADDR_W'(i)) thr_q[i] <= wdata;
    end
    assign thr_flat[i*DW +: DW] = thr_q[i];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++)
      if (addr == ADDR_W'(i)) rdata = thr_q[i];
  end

  // R2
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr < ADDR_W'(NCH)) |=> thr_q[$past(addr)] == $past(wdata));
  // R3
  wr_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr >= ADDR_W'(NCH)) |=> $stable(thr_flat));
endmodule

// File: rtl/trig_cmp_bank.sv
module trig_cmp_bank #(
  parameter int NCH = 4,
  parameter int DW  = 10
) (
  input  logic [NCH*DW-1:0] samples,
  input  logic [NCH*DW-1:0] thresholds,
  output logic [NCH-1:0]    hits
);
  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    assign hits[i] = samples[i*DW +: DW] > thresholds[i*DW +: DW];
  end
endmodule

// File: rtl/trig_slot_ser.sv
module trig_slot_ser
  import trig_serializer_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int SLOT_CYCLES = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [NCH-1:0] in_bits,
  output logic           line
);
  localparam int SLW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int CW  = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;

  ser_state_e     st_q;
  logic [NCH-1:0] frame_q, pend_bits_q;
  logic           pend_q;
  logic [SLW-1:0] slot_q;
  logic [CW-1:0]  cyc_q;
  logic           slot_last, cyc_last, frame_end, accept, sending;

  assign sending   = (st_q == SER_SEND);
  assign slot_last = (slot_q == SLW'(NCH - 1));
  assign cyc_last  = (cyc_q == CW'(SLOT_CYCLES - 1));
  assign frame_end = sending && slot_last && cyc_last;
  assign in_ready  = !pend_q;
  assign accept    = in_valid && in_ready;
  assign line      = sending && frame_q[slot_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= SER_IDLE;
      frame_q     <= '0;
      pend_bits_q <= '0;
      pend_q      <= 1'b0;
      slot_q      <= '0;
      cyc_q       <= '0;
    end else if (!sending || frame_end) begin
      slot_q <= '0;
      cyc_q  <= '0;
      if (pend_q) begin
        frame_q <= pend_bits_q;
        pend_q  <= 1'b0;
        st_q    <= SER_SEND;
      end else if (accept) begin
        frame_q <= in_bits;
        st_q    <= SER_SEND;
      end else begin
        st_q <= SER_IDLE;
      end
    end else begin
      if (cyc_last) begin
        cyc_q  <= '0;
        slot_q <= slot_q + 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
      if (accept) begin
        pend_q      <= 1'b1;
        pend_bits_q <= in_bits;
      end
    end
  end

  // R5
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && !frame_end) |=> st_q == SER_SEND);
  // R5
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && cyc_last && !slot_last) |=> slot_q == SLW'($past(slot_q) + 1'b1));
  // R7
  frame_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && !frame_end) |=> $stable(frame_q));
  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !frame_end) |=> pend_q);
  // R8
  pend_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && frame_end) |=> (sending && slot_q == '0 && !pend_q));
endmodule

// File: rtl/trig_serializer.sv
module trig_serializer #(
  parameter int NCH         = 4,
  parameter int DW          = 10,
  parameter int ADDR_W      = 3,
  parameter int SLOT_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [NCH*DW-1:0] smp_data,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  output logic              trig_line
);
  logic [NCH*DW-1:0] thr_flat;
  logic [NCH-1:0]    hits;

  trig_thr_regs #(.NCH(NCH), .DW(DW), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .thr_flat(thr_flat)
  );

  trig_cmp_bank #(.NCH(NCH), .DW(DW)) u_cmp (
    .samples(smp_data), .thresholds(thr_flat), .hits(hits)
  );

  trig_slot_ser #(.NCH(NCH), .SLOT_CYCLES(SLOT_CYCLES)) u_ser (
    .clk(clk), .rst_n(rst_n), .in_valid(smp_valid), .in_ready(smp_ready),
    .in_bits(hits), .line(trig_line)
  );
endmodule

// File: tb/trig_serializer_bench.sv
`timescale 1ns/1ps
module trig_serializer_bench;
  localparam int S = 2;
  localparam int NV = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [39:0] smp_data = '0;
  logic        cfg_wr_en = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [9:0]  cfg_wdata = '0;
  logic [9:0]  cfg_rdata;
  logic        trig_line;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  trig_serializer #(.SLOT_CYCLES(S)) u_trig_serializer (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .trig_line(trig_line)
  );

  // samples {ch4,ch3,ch2,ch1}; thresholds 100,200,300,400; expected bit0 = ch1
  localparam logic [39:0] VDATA [NV] = '{
    {10'd0,   10'd0,   10'd0,   10'd0},
    {10'd400, 10'd300, 10'd200, 10'd100},
    {10'd401, 10'd301, 10'd201, 10'd101},
    {10'd0,   10'd0,   10'd0,   10'd101},
    {10'd1023,10'd0,   10'd0,   10'd0},
    {10'd401, 10'd299, 10'd500, 10'd99}
  };
  localparam logic [3:0] VEXP [NV] = '{4'b0000, 4'b0000, 4'b1111, 4'b0001, 4'b1000, 4'b1010};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [9:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] a, input logic [9:0] exp, input string req);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  // starts at the first negedge after the accepting edge
  task automatic check_frame(input logic [3:0] bits, input string req);
    for (int k = 0; k < 4; k++)
      for (int c = 0; c < S; c++) begin
        check(req, trig_line, bits[k]);
        @(negedge clk);
      end
  endtask

  task automatic offer(input logic [39:0] d);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", trig_line, 1'b0);
    check("R1", smp_ready, 1'b1);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cfg_read(3'(i), 10'h3FF, "R1");
    offer({4{10'd1023}});
    check_frame(4'b0000, "R1");
    check("R6", trig_line, 1'b0);

    // R2 programming and read-back
    cfg_write(3'd0, 10'd100);
    cfg_write(3'd1, 10'd200);
    cfg_write(3'd2, 10'd300);
    cfg_write(3'd3, 10'd400);
    cfg_read(3'd0, 10'd100, "R2");
    cfg_read(3'd1, 10'd200, "R2");
    cfg_read(3'd2, 10'd300, "R2");
    cfg_read(3'd3, 10'd400, "R2");

    // R3 unused addresses
    cfg_write(3'd4, 10'd0);
    cfg_write(3'd7, 10'd5);
    cfg_read(3'd5, 10'd0, "R3");
    cfg_read(3'd7, 10'd0, "R3");
    for (int i = 0; i < 4; i++) cfg_read(3'(i), 10'(100 * (i + 1)), "R3");

    // R4 R5 table of patterns
    for (int v = 0; v < NV; v++) begin
      offer(VDATA[v]);
      check_frame(VEXP[v], "R4_R5");
      check("R6", trig_line, 1'b0);
    end

    // R7 inputs and threshold change mid-frame
    @(negedge clk);
    smp_valid = 1'b1; smp_data = {10'd401, 10'd0, 10'd0, 10'd101};
    @(negedge clk);
    smp_valid = 1'b0;
    fork
      check_frame(4'b1001, "R7");
      begin
        smp_data = {4{10'd1023}};
        cfg_wr_en = 1'b1; cfg_addr = 3'd3; cfg_wdata = 10'd1023;
        @(negedge clk);
        cfg_wr_en = 1'b0;
      end
    join
    check("R6", trig_line, 1'b0);
    cfg_read(3'd3, 10'd1023, "R7");
    cfg_write(3'd3, 10'd400);

    // R8 R9 held set, back-pressure, back-to-back frames
    @(negedge clk);
    smp_valid = 1'b1; smp_data = {10'd0, 10'd301, 10'd0, 10'd101};
    @(negedge clk);
    fork
      begin
        check_frame(4'b0101, "R8");
        check_frame(4'b1010, "R8");
        for (int k = 0; k < 4; k++) begin
          check("R9", trig_line, 1'b0);
          @(negedge clk);
        end
      end
      begin
        smp_data = {10'd401, 10'd0, 10'd201, 10'd0};
        @(negedge clk);
        check("R8", smp_ready, 1'b0);
        smp_data = {4{10'd1023}};
        @(negedge clk);
        check("R9", smp_ready, 1'b0);
        smp_valid = 1'b0;
      end
    join
    check("R8", smp_ready, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule